// File: doc/BRIEF.md
# Voltage and Frequency Operating-Point Sequencer

This block moves a processor between eleven fixed operating points. Each point pairs a supply voltage with a clock frequency. Software asks for a point by index. The block then drives a 5-bit voltage code to an external buck regulator controller and a frequency setting in MHz to the clock PLL. The two changes are made in a safe order. When the point goes up, the voltage rises before the clock speeds up. When the point goes down, the clock slows before the voltage drops.

The block waits for the regulator to report that the new voltage has settled, bounded by a settle window. It also waits out the PLL relock time. While the clock is relocking, the block holds the core stalled.

A clamp sits on the regulator path and works apart from the index decode. No code above the programmed maximum ever reaches the regulator. Replies to requests arrive one cycle after the request. The current point index can be read back at all times.

Top module: `dvfs_seq`

## Requirements
- R1: Indices 0 to 10 are valid. A request with an index from 11 to 15 gets `rsp_bad` one cycle later. It causes no regulator or PLL load and leaves `cur_idx` unchanged.
- R2: The voltage code for index i is 8 + 2·i, giving 8 to 28. It is presented on `vreg_code` in the cycle in which `vreg_load` pulses.
- R3: If the table code exceeds `vmax`, then `vmax` is sent in its place. In that case `clamp_flag` is set and stays set until reset.
- R4: The regulator may not pulse `vreg_ready` within SETTLE_CYC cycles of a voltage load. If so, `settle_err` is set and stays set, and the sequence carries on.
- R5: The frequency for index i is 59 + floor(147·i/10) MHz, giving 59 to 206. It is presented on `pll_freq` with a `pll_load` pulse. `core_stall` rises in the cycle of `pll_load` and stays high for exactly RELOCK_CYC cycles.
- R6: For a higher index, the voltage load comes first and the frequency load follows. For a lower index, the frequency load comes first and the voltage load follows.
- R7: A request made while `busy` is high gets `rsp_busy` one cycle later. It is dropped without being queued and has no later effect. Busy takes precedence over an invalid index.
- R8: A request for the current index gets `rsp_ok` and `done` one cycle later. It produces no voltage or PLL load.
- R9: `cur_idx` changes only in the cycle `done` pulses, at the end of the full sequence. `done` pulses once for each accepted request.
- R10: After reset, the outputs are as follows:
  - `cur_idx` is 0.
  - `busy`, `core_stall` and both flags are low.
  - `vreg_code` is 8 and `pll_freq` is 59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_idx | input | 4 | Requested operating-point index |
| vmax | input | 5 | Highest voltage code allowed to reach the regulator |
| vreg_ready | input | 1 | Regulator settled pulse |
| rsp_ok | output | 1 | Request accepted |
| rsp_busy | output | 1 | Request refused, transition in progress |
| rsp_bad | output | 1 | Request refused, index out of range |
| vreg_code | output | 5 | Voltage code to the regulator controller |
| vreg_load | output | 1 | Voltage code load pulse |
| pll_freq | output | 8 | PLL frequency setting in MHz |
| pll_load | output | 1 | PLL frequency load pulse |
| core_stall | output | 1 | Core held during PLL relock |
| busy | output | 1 | Transition in progress |
| done | output | 1 | Transition complete pulse |
| cur_idx | output | 4 | Active operating-point index |
| clamp_flag | output | 1 | Sticky over-voltage clamp indicator |
| settle_err | output | 1 | Sticky regulator settle timeout |

## Verification
The bench checks the order of the two loads in both directions. A sequencer that always changed frequency first would overclock the core at a low voltage on an up-move.

It requests the point that is already active. A design without the shortcut would emit loads and stall the core for no reason.

It sends a second request part-way through a transition. A design that queued this request, or dropped it without a reply, would emit extra loads or leave the index wrong. The bench also lowers the maximum code below the table value, and it silences the regulator. A missing clamp shows up as a code above the limit. A missing timeout shows up as a hang or a clear `settle_err`.

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int NPTS       = 11,
  parameter int IW         = 4,
  parameter int VW         = 5,
  parameter int FW         = 8,
  parameter int VBASE      = 8,
  parameter int VSTEP      = 2,
  parameter int FMIN       = 59,
  parameter int FMAX       = 206,
  parameter int SETTLE_CYC = 5000,
  parameter int RELOCK_CYC = 7500,
  parameter int RST_IDX    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [IW-1:0] req_idx,
  input  logic [VW-1:0] vmax,
  input  logic          vreg_ready,
  output logic          rsp_ok,
  output logic          rsp_busy,
  output logic          rsp_bad,
  output logic [VW-1:0] vreg_code,
  output logic          vreg_load,
  output logic [FW-1:0] pll_freq,
  output logic          pll_load,
  output logic          core_stall,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] cur_idx,
  output logic          clamp_flag,
  output logic          settle_err
);
  localparam int TMAX = (SETTLE_CYC > RELOCK_CYC) ? SETTLE_CYC : RELOCK_CYC;
  localparam int CW   = $clog2(TMAX + 1);

  function automatic logic [VW-1:0] vcode_of(input logic [IW-1:0] i);
    return VW'(VBASE + VSTEP * int'(i));
  endfunction

  function automatic logic [FW-1:0] freq_of(input logic [IW-1:0] i);
    return FW'(FMIN + ((FMAX - FMIN) * int'(i)) / (NPTS - 1));
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_VOLT, S_FREQ} st_t;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] tgt;
  logic          second;

  wire [IW-1:0] sel    = (st == S_IDLE) ? req_idx : tgt;
  wire [VW-1:0] raw_v  = vcode_of(sel);
  wire          over   = raw_v > vmax;
  wire [VW-1:0] safe_v = over ? vmax : raw_v;
  wire          idx_ok = int'(req_idx) < NPTS;
  wire          v_end  = vreg_ready || (cnt == CW'(SETTLE_CYC - 1));
  wire          f_end  = cnt == CW'(RELOCK_CYC - 1);

  assign busy       = st != S_IDLE;
  assign core_stall = st == S_FREQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      tgt        <= IW'(RST_IDX);
      second     <= 1'b0;
      cur_idx    <= IW'(RST_IDX);
      vreg_code  <= vcode_of(IW'(RST_IDX));
      pll_freq   <= freq_of(IW'(RST_IDX));
      vreg_load  <= 1'b0;
      pll_load   <= 1'b0;
      done       <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_busy   <= 1'b0;
      rsp_bad    <= 1'b0;
      clamp_flag <= 1'b0;
      settle_err <= 1'b0;
    end else begin
      vreg_load <= 1'b0;
      pll_load  <= 1'b0;
      done      <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_busy  <= req_valid && busy;
      rsp_bad   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (!idx_ok) rsp_bad <= 1'b1;
          else begin
            rsp_ok <= 1'b1;
            if (req_idx == cur_idx) done <= 1'b1;
            else begin
              tgt    <= req_idx;
              second <= 1'b0;
              cnt    <= '0;
              if (req_idx > cur_idx) begin
                vreg_code  <= safe_v;
                vreg_load  <= 1'b1;
                clamp_flag <= clamp_flag | over;
                st         <= S_VOLT;
              end else begin
                pll_freq <= freq_of(req_idx);
                pll_load <= 1'b1;
                st       <= S_FREQ;
              end
            end
          end
        end
        S_VOLT: begin
          if (v_end) begin
            if (!vreg_ready) settle_err <= 1'b1;
            cnt <= '0;
            if (second) begin
              st      <= S_IDLE;
              cur_idx <= tgt;
              done    <= 1'b1;
            end else begin
              second   <= 1'b1;
              pll_freq <= freq_of(tgt);
              pll_load <= 1'b1;
              st       <= S_FREQ;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_FREQ: begin
          if (f_end) begin
            cnt <= '0;
            if (second) begin
              st      <= S_IDLE;
              cur_idx <= tgt;
              done    <= 1'b1;
            end else begin
              second     <= 1'b1;
              vreg_code  <= safe_v;
              vreg_load  <= 1'b1;
              clamp_flag <= clamp_flag | over;
              st         <= S_VOLT;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_idx) < NPTS);

  // R3
  vclamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_load |-> vreg_code <= $past(vmax));

  // R3
  clamp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_flag |=> clamp_flag);

  // R5
  stall_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_load |-> core_stall);

  // R7
  one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ok, rsp_busy, rsp_bad}));

  // R9
  idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> done);

  // R6
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vreg_load && pll_load));
endmodule

// File: tb/sim_dvfs_seq.sv
module sim_dvfs_seq;
  localparam int SETTLE  = 40;
  localparam int RELOCK  = 60;
  localparam int REG_DLY = 10;
  localparam logic [3:0] K_OK = 1, K_BUSY = 2, K_BAD = 3, K_V = 4, K_P = 5, K_DONE = 6;

  logic clk = 0, rst_n = 0, req_valid = 0, vreg_ready = 0;
  logic [3:0] req_idx = 0;
  logic [4:0] vmax = 5'd31;
  logic rsp_ok, rsp_busy, rsp_bad, vreg_load, pll_load, core_stall, busy, done;
  logic clamp_flag, settle_err;
  logic [4:0] vreg_code;
  logic [7:0] pll_freq;
  logic [3:0] cur_idx;

  always #10 clk = ~clk;

  dvfs_seq #(.SETTLE_CYC(SETTLE), .RELOCK_CYC(RELOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx), .vmax(vmax),
    .vreg_ready(vreg_ready), .rsp_ok(rsp_ok), .rsp_busy(rsp_busy), .rsp_bad(rsp_bad),
    .vreg_code(vreg_code), .vreg_load(vreg_load), .pll_freq(pll_freq), .pll_load(pll_load),
    .core_stall(core_stall), .busy(busy), .done(done), .cur_idx(cur_idx),
    .clamp_flag(clamp_flag), .settle_err(settle_err));

  int checks = 0, fails = 0;
  logic [15:0] sbq[$];
  int model_cur = 0;
  logic reg_dead = 0;
  int rcnt = 0;
  int stall_len = 0;

  always @(posedge clk) begin
    vreg_ready <= 1'b0;
    if (vreg_load) rcnt <= REG_DLY;
    else if (rcnt != 0) begin
      rcnt <= rcnt - 1;
      if (rcnt == 1 && !reg_dead) vreg_ready <= 1'b1;
    end
  end

  function automatic int vc(int i); return 8 + 2 * i; endfunction
  function automatic int fq(int i); return 59 + (147 * i) / 10; endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pop_chk(logic [3:0] k, int val, string tag);
    logic [15:0] e;
    checks++;
    if (sbq.size() == 0) begin
      fails++;
      $display("FAIL %s actual=event%0d:%0d expected=none", tag, k, val);
    end else begin
      e = sbq.pop_front();
      if (e != {k, 12'(val)}) begin
        fails++;
        $display("FAIL %s actual=event%0d:%0d expected=event%0d:%0d", tag, k, val, e[15:12], e[11:0]);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rsp_ok)    pop_chk(K_OK, 0, "R1/R8 reply");
    if (rsp_busy)  pop_chk(K_BUSY, 0, "R7 busy reply");
    if (rsp_bad)   pop_chk(K_BAD, 0, "R1 invalid reply");
    if (vreg_load) pop_chk(K_V, int'(vreg_code), "R2/R3/R6 voltage load");
    if (pll_load)  pop_chk(K_P, int'(pll_freq), "R5/R6 pll load");
    if (done)      pop_chk(K_DONE, int'(cur_idx), "R9 done index");
    if (core_stall) stall_len++;
    else if (stall_len != 0) begin
      check("R5 stall length", stall_len, RELOCK);
      stall_len = 0;
    end
  end

  task automatic push(logic [3:0] k, int v); sbq.push_back({k, 12'(v)}); endtask

  function automatic int lim(int v); return (v > int'(vmax)) ? int'(vmax) : v; endfunction

  task automatic drive(int i);
    @(negedge clk);
    req_valid = 1; req_idx = 4'(i);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain(string tag);
    int n = 0;
    while ((sbq.size() != 0 || busy) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
    check({tag, " queue drained"}, sbq.size(), 0);
  endtask

  task automatic request(int i);
    if (i > 10) push(K_BAD, 0);
    else if (i == model_cur) begin push(K_OK, 0); push(K_DONE, i); end
    else begin
      push(K_OK, 0);
      if (i > model_cur) begin push(K_V, lim(vc(i))); push(K_P, fq(i)); end
      else begin push(K_P, fq(i)); push(K_V, lim(vc(i))); end
      push(K_DONE, i);
      model_cur = i;
    end
    drive(i);
    drain("R9");
    check("R9 cur_idx", int'(cur_idx), model_cur);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 cur_idx", int'(cur_idx), 0);
    check("R10 busy", int'(busy), 0);
    check("R10 stall", int'(core_stall), 0);
    check("R10 clamp", int'(clamp_flag), 0);
    check("R10 err", int'(settle_err), 0);
    check("R10 vcode", int'(vreg_code), 8);
    check("R10 freq", int'(pll_freq), 59);

    request(3);
    request(3);
    request(12);
    request(15);
    request(1);
    request(10);
    request(0);

    push(K_OK, 0); push(K_V, vc(5));
    drive(5);
    @(negedge clk);
    check("R7 busy high", int'(busy), 1);
    push(K_BUSY, 0);
    drive(7);
    check("R9 index held mid-sequence", int'(cur_idx), 0);
    push(K_P, fq(5)); push(K_DONE, 5);
    model_cur = 5;
    drain("R7");
    repeat (100) @(negedge clk);
    check("R7 no queued work", sbq.size(), 0);
    check("R7 cur_idx", int'(cur_idx), 5);

    vmax = 5'd20;
    check("R3 flag before", int'(clamp_flag), 0);
    request(10);
    check("R3 clamp flag", int'(clamp_flag), 1);
    request(2);
    check("R3 flag sticky", int'(clamp_flag), 1);
    check("R2 code below limit", int'(vreg_code), 12);

    vmax = 5'd31;
    reg_dead = 1;
    check("R4 err before", int'(settle_err), 0);
    request(4);
    check("R4 settle error", int'(settle_err), 1);
    check("R4 vreg code", int'(vreg_code), vc(4));
    check("R4 pll freq", int'(pll_freq), fq(4));
    reg_dead = 0;
    summary();
  end
endmodule